// File: doc/BRIEF.md
# Broadcast Bus Node with Handshake and Cycle-Synchronous Modes

This block puts one requesting agent and one memory-backed responder on a shared broadcast bus. Every message on the bus carries a destination address, a two-bit command and a data word, and every attached agent sees every message. The responder claims a message by comparing only the high-order select bits of the destination address with its own select value, and it takes no action on anything else. Its word index comes from the lowest address bits, so the address bits between the select field and the index play no part in the match or in the word chosen.

A read is carried out as two messages. The requester sends a read request whose data field holds its own bus address. The responder later sends a response message addressed back to the requester, and the requester captures the value from it. A build-time parameter selects one of two transfer disciplines. In the first, each message is framed by a return-to-zero ready/acknowledge exchange. In the second, a message occupies the bus for exactly one clock and the receiver samples the bus every cycle. The requester aborts with an error flag if no answer arrives within a parameterised number of cycles.

The local side is a single-request port: a request is accepted only while `req_ready` is high, and its completion is reported by a one-cycle `rsp_done` pulse.

Top module: `bbus_node`

## Requirements
- R1: During and right after reset, `bus_cmd` is idle (2'b00), `bus_rdy`, `bus_ack`, `rsp_done` and `rsp_err` are low, and `req_ready` is high.
- R2: A write (command 2'b01) to a claimed address followed by a read (request command 2'b10) of the same address returns the written word on `rsp_rdata` with `rsp_err` low; unwritten words read as zero.
- R3: The responder claims a message only when address bits [ADDR_W-1 -: SEL_W] equal SLAVE_SEL (default 4'h3); it selects the word with the low IDX_W bits (default 4), so addresses differing only in the bits between those fields reach the same word.
- R4: A message whose select bits differ from SLAVE_SEL gets no acknowledge and changes no stored word; in handshake mode a write or read to it, and in synchronous mode a read to it, ends with `rsp_done` and `rsp_err` both high after TIMEOUT cycles of waiting.
- R5: In handshake mode, acknowledge rises only while ready is high, ready falls only after acknowledge was high or together with an error completion, and acknowledge falls only after ready was seen low.
- R6: A read request message carries in its data field the requester's bus address, {MASTER_SEL, zeros} (0x100 by default); the response uses command 2'b11, is addressed to that bus address and carries the stored word; only one agent drives the bus at a time.
- R7: In synchronous mode `bus_rdy` and `bus_ack` stay low, each request message is on the bus for exactly one cycle, and a write completes on the cycle after its message.
- R8: In synchronous mode the response to a claimed read is on the bus in the cycle right after the request, and `rsp_done` with the data follows one cycle later.
- R9: A request presented while `req_ready` is low is dropped and leaves no trace in the stored words.
- R10: `rsp_done` is high for exactly one cycle per accepted request, and `rsp_err` is never high without `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Destination bus address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Requester idle, request will be accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended by timeout |
| rsp_rdata | output | DATA_W | Read result, valid with `rsp_done` |
| bus_addr | output | ADDR_W | Shared bus destination address |
| bus_cmd | output | 2 | Shared bus command: 00 idle, 01 write, 10 read request, 11 response |
| bus_data | output | DATA_W | Shared bus data field |
| bus_rdy | output | 1 | Shared ready line |
| bus_ack | output | 1 | Shared acknowledge line |

## Verification
The assertions watch, on every cycle, the ordering of the ready and acknowledge edges, the rule that at most one agent drives the bus, that every response is addressed to the requester, the one-cycle message occupancy and next-cycle response of the synchronous mode, and the shape of the completion pulse. What only the bench scenarios show is data correctness: the values returned after writes, aliasing through the ignored middle address bits, words left untouched by unclaimed or dropped requests, the exact synchronous timing seen at the ports, and the error result after the timeout window.

// File: rtl/bbus_pkg.sv
package bbus_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RD   = 2'b10,
        CMD_RSP  = 2'b11
    } bcmd_e;
endpackage

// File: rtl/bbus_master.sv
module bbus_master
    import bbus_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned SEL_W      = 4,
    parameter int unsigned MASTER_SEL = 1,
    parameter int unsigned TIMEOUT    = 16,
    parameter bit          HANDSHAKE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  bcmd_e             bus_cmd_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              bus_rdy_i,
    input  logic              bus_ack_i,
    output logic [ADDR_W-1:0] m_addr_o,
    output bcmd_e             m_cmd_o,
    output logic [DATA_W-1:0] m_data_o,
    output logic              m_rdy_o,
    output logic              m_ack_o,
    output logic              m_own_o
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [SEL_W-1:0]  MSEL    = SEL_W'(MASTER_SEL);
    localparam logic [ADDR_W-1:0] MY_ADDR = {MSEL, {(ADDR_W-SEL_W){1'b0}}};
    localparam logic [CNT_W-1:0]  LIMIT   = CNT_W'(TIMEOUT - 1);

    typedef enum logic [2:0] {M_IDLE, M_PUT, M_REQ, M_DROP, M_WAIT, M_RACK} mst_e;

    typedef struct packed {
        mst_e              st;
        logic [ADDR_W-1:0] addr;
        bcmd_e             cmd;
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              ack;
        logic              own;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [CNT_W-1:0]  cnt;
    } mst_s;

    mst_s q, d;
    logic rsp_hit, timed_out;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        rsp_hit   = (bus_cmd_i == CMD_RSP) && (bus_addr_i[ADDR_W-1 -: SEL_W] == MSEL);
        timed_out = (q.cnt == LIMIT);
        case (q.st)
            M_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.cmd  = req_write ? CMD_WR : CMD_RD;
                    d.data = req_write ? req_wdata : DATA_W'(MY_ADDR);
                    d.own  = 1'b1;
                    d.cnt  = '0;
                    d.st   = M_PUT;
                end
            end
            M_PUT: begin
                if (HANDSHAKE) begin
                    d.rdy = 1'b1;
                    d.st  = M_REQ;
                end else begin
                    d.own = 1'b0;
                    if (q.cmd == CMD_WR) begin
                        d.done = 1'b1;
                        d.st   = M_IDLE;
                    end else begin
                        d.st = M_WAIT;
                    end
                end
            end
            M_REQ: begin
                if (bus_ack_i) begin
                    d.rdy = 1'b0;
                    d.own = 1'b0;
                    d.cnt = '0;
                    d.st  = M_DROP;
                end else if (timed_out) begin
                    d.rdy  = 1'b0;
                    d.own  = 1'b0;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = M_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            M_DROP: begin
                if (!bus_ack_i) begin
                    d.cnt = '0;
                    if (q.cmd == CMD_WR) begin
                        d.done = 1'b1;
                        d.st   = M_IDLE;
                    end else begin
                        d.st = M_WAIT;
                    end
                end else if (timed_out) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = M_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            M_WAIT: begin
                if (rsp_hit && (bus_rdy_i || !HANDSHAKE)) begin
                    d.rdata = bus_data_i;
                    d.cnt   = '0;
                    if (HANDSHAKE) begin
                        d.ack = 1'b1;
                        d.st  = M_RACK;
                    end else begin
                        d.done = 1'b1;
                        d.st   = M_IDLE;
                    end
                end else if (timed_out) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = M_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            M_RACK: begin
                if (!bus_rdy_i) begin
                    d.ack  = 1'b0;
                    d.done = 1'b1;
                    d.st   = M_IDLE;
                end else if (timed_out) begin
                    d.ack  = 1'b0;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = M_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= M_IDLE;
            q.cmd   <= CMD_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == M_IDLE);
    assign rsp_done  = q.done;
    assign rsp_err   = q.err;
    assign rsp_rdata = q.rdata;
    assign m_addr_o  = q.addr;
    assign m_cmd_o   = q.cmd;
    assign m_data_o  = q.data;
    assign m_rdy_o   = q.rdy;
    assign m_ack_o   = q.ack;
    assign m_own_o   = q.own;
endmodule

// File: rtl/bbus_slave.sv
module bbus_slave
    import bbus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned SLAVE_SEL = 3,
    parameter int unsigned IDX_W     = 4,
    parameter bit          HANDSHAKE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  bcmd_e             bus_cmd_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              bus_rdy_i,
    input  logic              bus_ack_i,
    output logic [ADDR_W-1:0] s_addr_o,
    output bcmd_e             s_cmd_o,
    output logic [DATA_W-1:0] s_data_o,
    output logic              s_rdy_o,
    output logic              s_ack_o,
    output logic              s_own_o
);
    localparam int unsigned     WORDS = 1 << IDX_W;
    localparam logic [SEL_W-1:0] SSEL = SEL_W'(SLAVE_SEL);

    typedef enum logic [2:0] {S_IDLE, S_ACK, S_PUT, S_RDY, S_DROP} slv_e;

    typedef struct packed {
        slv_e              st;
        logic              rd_pend;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              rdy;
        logic              ack;
        logic              own;
    } slv_s;

    slv_s q, d;
    logic [DATA_W-1:0] mem_q [WORDS];
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic              claim;

    always_comb begin
        d     = q;
        we    = 1'b0;
        idx   = bus_addr_i[IDX_W-1:0];
        claim = (bus_addr_i[ADDR_W-1 -: SEL_W] == SSEL);
        if (!HANDSHAKE) begin
            d.own = 1'b0;
            if (claim && !q.own) begin
                if (bus_cmd_i == CMD_WR) begin
                    we = 1'b1;
                end else if (bus_cmd_i == CMD_RD) begin
                    d.own  = 1'b1;
                    d.addr = bus_data_i[ADDR_W-1:0];
                    d.data = mem_q[idx];
                end
            end
        end else begin
            case (q.st)
                S_IDLE: begin
                    if (bus_rdy_i && claim &&
                        (bus_cmd_i == CMD_WR || bus_cmd_i == CMD_RD)) begin
                        we        = (bus_cmd_i == CMD_WR);
                        d.rd_pend = (bus_cmd_i == CMD_RD);
                        d.addr    = bus_data_i[ADDR_W-1:0];
                        d.data    = mem_q[idx];
                        d.ack     = 1'b1;
                        d.st      = S_ACK;
                    end
                end
                S_ACK: begin
                    if (!bus_rdy_i) begin
                        d.ack = 1'b0;
                        if (q.rd_pend) begin
                            d.own = 1'b1;
                            d.st  = S_PUT;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                S_PUT: begin
                    d.rdy = 1'b1;
                    d.st  = S_RDY;
                end
                S_RDY: begin
                    if (bus_ack_i) begin
                        d.rdy = 1'b0;
                        d.own = 1'b0;
                        d.st  = S_DROP;
                    end
                end
                S_DROP: begin
                    if (!bus_ack_i) d.st = S_IDLE;
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= bus_data_i;
        end
    end

    assign s_addr_o = q.addr;
    assign s_cmd_o  = q.own ? CMD_RSP : CMD_IDLE;
    assign s_data_o = q.data;
    assign s_rdy_o  = q.rdy;
    assign s_ack_o  = q.ack;
    assign s_own_o  = q.own;
endmodule

// File: rtl/bbus_node.sv
module bbus_node
    import bbus_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned SEL_W      = 4,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned SLAVE_SEL  = 3,
    parameter int unsigned MASTER_SEL = 1,
    parameter int unsigned TIMEOUT    = 16,
    parameter bit          HANDSHAKE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_cmd,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_rdy,
    output logic              bus_ack
);
    logic [ADDR_W-1:0] m_addr, s_addr, addr_mux;
    logic [DATA_W-1:0] m_data, s_data, data_mux;
    bcmd_e             m_cmd, s_cmd, cmd_mux;
    logic              m_rdy, m_ack, m_own;
    logic              s_rdy, s_ack, s_own;

    bbus_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .MASTER_SEL(MASTER_SEL), .TIMEOUT(TIMEOUT), .HANDSHAKE(HANDSHAKE)
    ) u_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_addr_i(addr_mux), .bus_cmd_i(cmd_mux), .bus_data_i(data_mux),
        .bus_rdy_i(bus_rdy), .bus_ack_i(bus_ack),
        .m_addr_o(m_addr), .m_cmd_o(m_cmd), .m_data_o(m_data),
        .m_rdy_o(m_rdy), .m_ack_o(m_ack), .m_own_o(m_own)
    );

    bbus_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .SLAVE_SEL(SLAVE_SEL), .IDX_W(IDX_W), .HANDSHAKE(HANDSHAKE)
    ) u_slave (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(addr_mux), .bus_cmd_i(cmd_mux), .bus_data_i(data_mux),
        .bus_rdy_i(bus_rdy), .bus_ack_i(bus_ack),
        .s_addr_o(s_addr), .s_cmd_o(s_cmd), .s_data_o(s_data),
        .s_rdy_o(s_rdy), .s_ack_o(s_ack), .s_own_o(s_own)
    );

    always_comb begin
        if (m_own) begin
            addr_mux = m_addr;
            cmd_mux  = m_cmd;
            data_mux = m_data;
        end else if (s_own) begin
            addr_mux = s_addr;
            cmd_mux  = s_cmd;
            data_mux = s_data;
        end else begin
            addr_mux = '0;
            cmd_mux  = CMD_IDLE;
            data_mux = '0;
        end
    end

    assign bus_addr = addr_mux;
    assign bus_cmd  = cmd_mux;
    assign bus_data = data_mux;
    assign bus_rdy  = m_rdy | s_rdy;
    assign bus_ack  = m_ack | s_ack;
endmodule

// File: rtl/bbus_node_chk.sv
module bbus_node_chk #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned SEL_W      = 4,
    parameter int unsigned SLAVE_SEL  = 3,
    parameter int unsigned MASTER_SEL = 1,
    parameter bit          HANDSHAKE  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_cmd,
    input logic              bus_rdy,
    input logic              bus_ack,
    input logic              m_own,
    input logic              s_own,
    input logic              rsp_done,
    input logic              rsp_err
);
    localparam logic [SEL_W-1:0]  MSEL    = SEL_W'(MASTER_SEL);
    localparam logic [SEL_W-1:0]  SSEL    = SEL_W'(SLAVE_SEL);
    localparam logic [ADDR_W-1:0] MY_ADDR = {MSEL, {(ADDR_W-SEL_W){1'b0}}};

    logic claimed;
    assign claimed = (bus_addr[ADDR_W-1 -: SEL_W] == SSEL);

    AST_ACK_RISE_IN_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> bus_rdy); // R5
    AST_RDY_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rdy) |-> ($past(bus_ack) || rsp_err)); // R5
    AST_ACK_FALL_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack) |-> !$past(bus_rdy)); // R5
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_own && s_own)); // R6
    AST_RSP_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'b11) |-> (bus_addr == MY_ADDR)); // R6
    AST_SYNC_NO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !HANDSHAKE |-> (!bus_rdy && !bus_ack)); // R7
    AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!HANDSHAKE && (bus_cmd == 2'b01 || bus_cmd == 2'b10))
        |=> (bus_cmd == 2'b00 || bus_cmd == 2'b11)); // R7
    AST_SYNC_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!HANDSHAKE && bus_cmd == 2'b10 && claimed) |=> (bus_cmd == 2'b11)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10
endmodule

bind bbus_node bbus_node_chk #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SLAVE_SEL(SLAVE_SEL),
    .MASTER_SEL(MASTER_SEL), .HANDSHAKE(HANDSHAKE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
    .bus_rdy(bus_rdy), .bus_ack(bus_ack), .m_own(m_own), .s_own(s_own),
    .rsp_done(rsp_done), .rsp_err(rsp_err)
);

// File: tb/bbus_node_bench.sv
module bbus_node_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        rv  [2];
    logic        rw  [2];
    logic [11:0] ra  [2];
    logic [15:0] rwd [2];
    logic        rdy_w  [2];
    logic        done_w [2];
    logic        err_w  [2];
    logic [15:0] rdat_w [2];
    logic [11:0] baddr  [2];
    logic [1:0]  bcmd   [2];
    logic [15:0] bdata  [2];
    logic        brdy   [2];
    logic        back   [2];

    bbus_node u_bbus_node (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_write(rw[0]),
        .req_addr(ra[0]), .req_wdata(rwd[0]), .req_ready(rdy_w[0]),
        .rsp_done(done_w[0]), .rsp_err(err_w[0]), .rsp_rdata(rdat_w[0]),
        .bus_addr(baddr[0]), .bus_cmd(bcmd[0]), .bus_data(bdata[0]),
        .bus_rdy(brdy[0]), .bus_ack(back[0])
    );

    bbus_node #(.HANDSHAKE(1'b0)) u_bbus_node_sync (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_write(rw[1]),
        .req_addr(ra[1]), .req_wdata(rwd[1]), .req_ready(rdy_w[1]),
        .rsp_done(done_w[1]), .rsp_err(err_w[1]), .rsp_rdata(rdat_w[1]),
        .bus_addr(baddr[1]), .bus_cmd(bcmd[1]), .bus_data(bdata[1]),
        .bus_rdy(brdy[1]), .bus_ack(back[1])
    );

    int checks = 0;
    int fails  = 0;

    // bus monitor on the handshake instance
    int          ack_cnt = 0;
    int          overlap_cnt = 0;
    logic [15:0] seen_rd_data = '0;
    logic [11:0] seen_rsp_addr = '0;
    always @(negedge clk) begin
        if (back[0]) ack_cnt++;
        if (brdy[0] && back[0]) overlap_cnt++;
        if (brdy[0] && bcmd[0] == 2'b10) seen_rd_data = bdata[0];
        if (brdy[0] && bcmd[0] == 2'b11) seen_rsp_addr = baddr[0];
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input int i, input logic wr, input logic [11:0] a,
                          input logic [15:0] d, output logic err, output logic [15:0] rd);
        @(negedge clk);
        rv[i] = 1'b1; rw[i] = wr; ra[i] = a; rwd[i] = d;
        @(negedge clk);
        rv[i] = 1'b0;
        for (int n = 0; n < 400 && !done_w[i]; n++) @(negedge clk);
        check("R10 completion seen", {31'd0, done_w[i]}, 32'd1);
        err = err_w[i];
        rd  = rdat_w[i];
        @(negedge clk);
        check("R10 done lasts one cycle", {31'd0, done_w[i]}, 32'd0);
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [15:0] data;
        logic        err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h305, 16'hA5A5, 1'b0},  // R2 write
        '{1'b0, 12'h305, 16'hA5A5, 1'b0},  // R2 read back
        '{1'b0, 12'h307, 16'h0000, 1'b0},  // R2 unwritten word
        '{1'b1, 12'h30F, 16'h1234, 1'b0},  // R2 write last word
        '{1'b0, 12'h3F5, 16'hA5A5, 1'b0},  // R3 middle bits ignored
        '{1'b1, 12'h3A0, 16'h0BEE, 1'b0},  // R3 alias write to word 0
        '{1'b0, 12'h300, 16'h0BEE, 1'b0},  // R3 alias read of word 0
        '{1'b1, 12'h505, 16'hDEAD, 1'b1},  // R4 unclaimed write
        '{1'b0, 12'h305, 16'hA5A5, 1'b0},  // R4 word unchanged
        '{1'b0, 12'h705, 16'h0000, 1'b1},  // R4 unclaimed read
        '{1'b0, 12'h30F, 16'h1234, 1'b0}   // R2 last word
    };

    initial begin
        logic        e;
        logic [15:0] r;
        int          acks_before;
        for (int i = 0; i < 2; i++) begin
            rv[i] = 1'b0; rw[i] = 1'b0; ra[i] = '0; rwd[i] = '0;
        end
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check("R1 bus_cmd idle", {30'd0, bcmd[i]}, 32'd0);
            check("R1 rdy/ack low", {30'd0, brdy[i], back[i]}, 32'd0);
            check("R1 done/err low", {30'd0, done_w[i], err_w[i]}, 32'd0);
            check("R1 req_ready high", {31'd0, rdy_w[i]}, 32'd1);
        end
        rst_n = 1'b1;

        // table walk on the handshake instance
        for (int k = 0; k < NV; k++) begin
            run_op(0, VEC[k].wr, VEC[k].addr, VEC[k].data, e, r);
            check($sformatf("R2/R3/R4 vec%0d err", k), {31'd0, e}, {31'd0, VEC[k].err});
            if (!VEC[k].wr && !VEC[k].err)
                check($sformatf("R2/R3 vec%0d rdata", k), {16'd0, r}, {16'd0, VEC[k].data});
        end

        // R5: handshake lines overlapped during claimed transfers
        checks++;
        if (overlap_cnt == 0) begin
            fails++;
            $display("FAIL R5 rdy/ack overlap actual=%0d expected>0", overlap_cnt);
        end

        // R4: unclaimed write raises no acknowledge
        acks_before = ack_cnt;
        run_op(0, 1'b1, 12'hC01, 16'h5555, e, r);
        check("R4 no ack for unclaimed", ack_cnt, acks_before);
        check("R4 err on unclaimed", {31'd0, e}, 32'd1);

        // R6: split read fields seen on the bus
        run_op(0, 1'b0, 12'h30F, 16'h0, e, r);
        check("R6 request carries requester", {16'd0, seen_rd_data}, 32'h100);
        check("R6 response addressed to requester", {20'd0, seen_rsp_addr}, 32'h100);
        check("R6 response data", {16'd0, r}, 32'h1234);

        // R9: request while busy is dropped
        @(negedge clk);
        rv[0] = 1'b1; rw[0] = 1'b1; ra[0] = 12'h301; rwd[0] = 16'h1111;
        @(negedge clk);
        check("R9 req_ready low while busy", {31'd0, rdy_w[0]}, 32'd0);
        ra[0] = 12'h302; rwd[0] = 16'h2222;
        repeat (3) @(negedge clk);
        rv[0] = 1'b0;
        for (int n = 0; n < 400 && !done_w[0]; n++) @(negedge clk);
        @(negedge clk);
        run_op(0, 1'b0, 12'h302, 16'h0, e, r);
        check("R9 dropped request left word", {16'd0, r}, 32'h0);
        run_op(0, 1'b0, 12'h301, 16'h0, e, r);
        check("R9 accepted request written", {16'd0, r}, 32'h1111);

        // R7: synchronous write timing
        @(negedge clk);
        rv[1] = 1'b1; rw[1] = 1'b1; ra[1] = 12'h305; rwd[1] = 16'h7777;
        @(negedge clk);
        rv[1] = 1'b0;
        check("R7 write message on bus", {30'd0, bcmd[1]}, 32'd1);
        check("R7 write address", {20'd0, baddr[1]}, 32'h305);
        check("R7 no rdy/ack", {30'd0, brdy[1], back[1]}, 32'd0);
        @(negedge clk);
        check("R7 bus released next cycle", {30'd0, bcmd[1]}, 32'd0);
        check("R7 write done", {30'd0, done_w[1], err_w[1]}, 32'd2);

        // R8: synchronous read timing
        @(negedge clk);
        rv[1] = 1'b1; rw[1] = 1'b0; ra[1] = 12'h3E5; rwd[1] = 16'h0;
        @(negedge clk);
        rv[1] = 1'b0;
        check("R6 sync request cmd", {30'd0, bcmd[1]}, 32'd2);
        check("R6 sync request data", {16'd0, bdata[1]}, 32'h100);
        @(negedge clk);
        check("R8 response next cycle", {30'd0, bcmd[1]}, 32'd3);
        check("R8 response address", {20'd0, baddr[1]}, 32'h100);
        check("R8 response data", {16'd0, bdata[1]}, 32'h7777);
        @(negedge clk);
        check("R8 done after response", {30'd0, done_w[1], err_w[1]}, 32'd2);
        check("R8 read data", {16'd0, rdat_w[1]}, 32'h7777);
        check("R7 no rdy/ack in sync", {30'd0, brdy[1], back[1]}, 32'd0);

        // R4: synchronous unclaimed read times out
        run_op(1, 1'b0, 12'h905, 16'h0, e, r);
        check("R4 sync unclaimed read err", {31'd0, e}, 32'd1);
        run_op(1, 1'b1, 12'h805, 16'h9999, e, r);
        run_op(1, 1'b0, 12'h305, 16'h0, e, r);
        check("R4 sync word unchanged", {16'd0, r}, 32'h7777);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule